// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received Ethernet frame as a byte stream, one byte per cycle with start and end markers, and scatters it into fixed 128-byte buffers in system memory. The buffer addresses come from a ring of two-word descriptors held inside the block. Word 0 of a descriptor is the buffer address, and its two low bits double as an ownership flag and an end-of-ring flag. Word 1 is the status that the block writes back when it finishes with a buffer: the frame length, per-buffer start and end markers, and the address-match flags that the MAC supplies together with the last byte.

Ownership is passed through the used bit (word 0, bit 0). The block sets this bit when it has filled a buffer. Software reads the descriptors through a word-wide port and returns each buffer by writing word 0 back with bit 0 clear. When the block reaches a descriptor that is still in use, it drops the rest of that frame, pulses an overrun flag, and stays on that descriptor. A frame longer than one buffer takes consecutive descriptors. At the end of the ring it continues at descriptor 0.

Top module: `rx_ring_writer`

## Requirements
- R1: An accepted byte at offset k of the current buffer is presented on the buffer write port one cycle later. The write address is (word 0 with bits 1:0 cleared) + k, and the byte offset runs from 0 to 127 inside each buffer.
- R2: A frame longer than 128 bytes fills buffers of exactly 128 bytes in consecutive descriptors. Every buffer that fills up gets a status writeback.
- R3: Status bits 11:0 hold the total frame length in bytes, but only in the buffer where the frame ends. Every other buffer of the frame gets 0 there.
- R4: Status bit 14 is set only in the first buffer of a frame, and status bit 15 is set only in its last buffer. A frame that fits in one buffer gets both bits.
- R5: The match inputs are sampled with the end byte. rx_match[0..3] go to status bits 26, 25, 24 and 23, rx_match[4] goes to bit 22, and rx_match[5] goes to bit 31. All of these bits are 0 in buffers that do not end a frame.
- R6: At writeback the block sets word 0 bit 0 (used) and writes word 1. This takes effect at the same clock edge as that buffer's final byte write, never earlier. The rest of word 0 is kept.
- R7: After the descriptor whose word 0 bit 1 is set, or after descriptor NDESC-1, the next buffer comes from descriptor 0. A frame may run across this wrap.
- R8: If a buffer is needed and its descriptor has bit 0 set, then:
  - no byte of the rest of that frame is written;
  - overrun is high for one cycle;
  - the pointer stays on that descriptor, and the next frame starts there.
- R9: Software writes either word through the port and reads either word combinationally. If software and a hardware writeback hit word 1 of the same descriptor in the same cycle, the hardware value wins. A software write to another descriptor in that cycle takes effect normally.
- R10: A writeback that is still in flight counts as owned for the ownership check. On a ring of one descriptor, a frame longer than one buffer therefore overruns on its second buffer.
- R11: A byte with rx_sof low that arrives outside a frame is ignored: it causes no buffer write and no status change.
- R12: After reset every descriptor word reads 0, the pointer is at descriptor 0, and buf_we and overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_match | input | 6 | Match flags, valid with the end byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | AW | Buffer byte write address |
| buf_data | output | 8 | Buffer byte write data |
| overrun | output | 1 | One-cycle pulse when a frame is dropped for lack of a buffer |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_idx | input | log2(NDESC) | Software descriptor index |
| sw_word | input | 1 | Selects word 0 (address) or word 1 (status) |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected descriptor word |

## Verification
The descriptor writeback for the end buffer lands one edge after the end byte is accepted. Software descriptor writes can fall in that same cycle. The bench places a software write in exactly that cycle by driving it on the falling edge right after the end byte. In one run the write targets word 1 of the descriptor being closed, and the read-back must show the hardware status. In another run it targets word 0 of an idle descriptor, and both that written value and the new status must appear. A second collision is between the ownership check and a writeback that has not yet landed, on a ring of one descriptor. There the bench expects exactly one overrun, and exactly 128 buffer writes for a 200-byte frame.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    localparam int ST_LEN_W = 12;
    localparam int ST_SOF   = 14;
    localparam int ST_EOF   = 15;
    localparam int ST_TYPE  = 22;
    localparam int ST_SA4   = 23;
    localparam int ST_SA3   = 24;
    localparam int ST_SA2   = 25;
    localparam int ST_SA1   = 26;
    localparam int ST_BCAST = 31;
    localparam int MATCH_W  = 6;

    function automatic logic [31:0] pack_status(
        input logic [ST_LEN_W-1:0] len,
        input logic                sof,
        input logic                eof,
        input logic [MATCH_W-1:0]  match
    );
        logic [31:0] s;
        s = '0;
        s[ST_LEN_W-1:0] = len;
        s[ST_SOF]   = sof;
        s[ST_EOF]   = eof;
        s[ST_SA1]   = match[0];
        s[ST_SA2]   = match[1];
        s[ST_SA3]   = match[2];
        s[ST_SA4]   = match[3];
        s[ST_TYPE]  = match[4];
        s[ST_BCAST] = match[5];
        return s;
    endfunction
endpackage

// File: rtl/rxring_desc_store.sv
module rxring_desc_store #(
    parameter int NDESC = 32,
    parameter int IDX_W = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_word,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic             hw_we,
    input  logic [IDX_W-1:0] hw_idx,
    input  logic [31:0]      hw_status,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word0
);
    logic [NDESC-1:0][31:0] addr_all;
    logic [NDESC-1:0][31:0] stat_all;

    for (genvar i = 0; i < NDESC; i++) begin : g_entry
        logic [31:0] a_d, a_q, s_d, s_q;

        always_comb begin
            a_d = a_q;
            s_d = s_q;
            if (sw_we && sw_idx == IDX_W'(i)) begin
                if (sw_word) s_d = sw_wdata;
                else         a_d = sw_wdata;
            end
            if (hw_we && hw_idx == IDX_W'(i)) begin
                a_d[0] = 1'b1;
                s_d    = hw_status;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                s_q <= '0;
            end else begin
                a_q <= a_d;
                s_q <= s_d;
            end
        end

        assign addr_all[i] = a_q;
        assign stat_all[i] = s_q;
    end

    assign sw_rdata = sw_word ? stat_all[sw_idx] : addr_all[sw_idx];
    assign rd_word0 = addr_all[rd_idx];
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int NDESC     = 32,
    parameter int BUF_BYTES = 128,
    parameter int AW        = 32,
    parameter int IDX_W     = $clog2(NDESC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic [MATCH_W-1:0] rx_match,
    input  logic [31:0]        rd_word0,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               wb_we,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [31:0]        wb_status,
    output logic               buf_we,
    output logic [AW-1:0]      buf_addr,
    output logic [7:0]         buf_data,
    output logic               overrun
);
    localparam int OFF_W = $clog2(BUF_BYTES);
    localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(BUF_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NDESC - 1);

    typedef struct packed {
        logic [IDX_W-1:0]    ptr;
        logic                in_frame;
        logic                drop;
        logic [OFF_W-1:0]    offset;
        logic [ST_LEN_W-1:0] flen;
        logic                first;
        logic [AW-1:0]       base;
        logic                bwe;
        logic [AW-1:0]       baddr;
        logic [7:0]          bdata;
        logic                ovr;
        logic                wbv;
        logic [IDX_W-1:0]    wbidx;
        logic [31:0]         wbstat;
    } ctrl_t;

    ctrl_t q, d;

    logic                used_now;
    logic                ring_end;
    logic [IDX_W-1:0]    nxt_ptr;
    logic [OFF_W-1:0]    cur_off;
    logic [ST_LEN_W-1:0] cur_len;
    logic                cur_first;
    logic [AW-1:0]       cur_base;
    logic                take;

    always_comb begin
        used_now  = rd_word0[0] | (q.wbv && q.wbidx == q.ptr);
        ring_end  = rd_word0[1] || (q.ptr == IDX_MAX);
        nxt_ptr   = ring_end ? '0 : q.ptr + 1'b1;
        cur_off   = rx_sof ? '0 : q.offset;
        cur_len   = rx_sof ? '0 : q.flen;
        cur_first = rx_sof ? 1'b1 : q.first;
        cur_base  = (cur_off == '0) ? (rd_word0[AW-1:0] & ~AW'(3)) : q.base;
        take      = rx_valid && (rx_sof || (q.in_frame && !q.drop));

        d     = q;
        d.bwe = 1'b0;
        d.ovr = 1'b0;
        d.wbv = 1'b0;

        if (take) begin
            if (cur_off == '0 && used_now) begin
                d.ovr      = 1'b1;
                d.drop     = !rx_eof;
                d.in_frame = !rx_eof;
                d.offset   = '0;
            end else begin
                d.bwe      = 1'b1;
                d.baddr    = cur_base + AW'(cur_off);
                d.bdata    = rx_data;
                d.base     = cur_base;
                d.flen     = cur_len + 1'b1;
                d.in_frame = !rx_eof;
                d.drop     = 1'b0;
                if (rx_eof || cur_off == OFF_MAX) begin
                    d.wbv    = 1'b1;
                    d.wbidx  = q.ptr;
                    d.wbstat = pack_status(rx_eof ? cur_len + 1'b1 : '0,
                                           cur_first, rx_eof,
                                           rx_eof ? rx_match : '0);
                    d.ptr    = nxt_ptr;
                    d.offset = '0;
                    d.first  = 1'b0;
                end else begin
                    d.offset = cur_off + 1'b1;
                    d.first  = cur_first;
                end
            end
        end else if (rx_valid && q.in_frame && q.drop && rx_eof) begin
            d.in_frame = 1'b0;
            d.drop     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_idx    = q.ptr;
    assign wb_we     = q.wbv;
    assign wb_idx    = q.wbidx;
    assign wb_status = q.wbstat;
    assign buf_we    = q.bwe;
    assign buf_addr  = q.baddr;
    assign buf_data  = q.bdata;
    assign overrun   = q.ovr;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxring_pkg::*;
#(
    parameter int NDESC     = 32,
    parameter int BUF_BYTES = 128,
    parameter int AW        = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_data,
    input  logic                     rx_sof,
    input  logic                     rx_eof,
    input  logic [5:0]               rx_match,
    output logic                     buf_we,
    output logic [AW-1:0]            buf_addr,
    output logic [7:0]               buf_data,
    output logic                     overrun,
    input  logic                     sw_we,
    input  logic [$clog2(NDESC)-1:0] sw_idx,
    input  logic                     sw_word,
    input  logic [31:0]              sw_wdata,
    output logic [31:0]              sw_rdata
);
    localparam int IDX_W = $clog2(NDESC);

    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      rd_word0;
    logic             wb_we;
    logic [IDX_W-1:0] wb_idx;
    logic [31:0]      wb_status;

    rxring_ctrl #(
        .NDESC(NDESC), .BUF_BYTES(BUF_BYTES), .AW(AW), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_match(rx_match),
        .rd_word0(rd_word0), .rd_idx(rd_idx),
        .wb_we(wb_we), .wb_idx(wb_idx), .wb_status(wb_status),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .overrun(overrun)
    );

    rxring_desc_store #(
        .NDESC(NDESC), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_idx(sw_idx), .sw_word(sw_word),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .hw_we(wb_we), .hw_idx(wb_idx), .hw_status(wb_status),
        .rd_idx(rd_idx), .rd_word0(rd_word0)
    );
endmodule

// File: rtl/rxring_checker.sv
module rxring_checker #(
    parameter int BUF_BYTES = 128,
    parameter int AW        = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          buf_we,
    input logic [AW-1:0] buf_addr,
    input logic          overrun,
    input logic          hw_we,
    input logic [31:0]   hw_status
);
    localparam int OFF_W = $clog2(BUF_BYTES);

    // R1: bytes inside one buffer go to consecutive addresses
    p_seq_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we) && buf_addr[OFF_W-1:0] != '0)
        |-> buf_addr == $past(buf_addr) + AW'(1));

    // R2: a buffer closed without the end marker was filled to its last byte
    p_full_buffer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && !hw_status[15]) |-> (buf_we && buf_addr[OFF_W-1:0] == '1));

    // R3: the length in the end buffer agrees with the final byte offset
    p_len_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && hw_status[15])
        |-> buf_addr[OFF_W-1:0] == OFF_W'(hw_status[11:0] - 12'd1));

    // R3: no length in a buffer that does not end the frame
    p_len_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && !hw_status[15]) |-> hw_status[11:0] == 12'd0);

    // R5: no match flags in a buffer that does not end the frame
    p_flags_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && !hw_status[15]) |-> (hw_status[31] == 1'b0 && hw_status[26:22] == 5'd0));

    // R6: ownership passes together with the buffer's final byte write
    p_wb_with_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we |-> buf_we);

    // R8: a dropped frame writes nothing in the overrun cycle
    p_ovr_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (!buf_we && !hw_we));
endmodule

bind rx_ring_writer rxring_checker #(.BUF_BYTES(BUF_BYTES), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr),
    .overrun(overrun), .hw_we(wb_we), .hw_status(wb_status)
);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
    localparam int NDESC = 32;
    localparam int BB    = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [5:0]  rx_match = '0;
    logic        buf_we, overrun;
    logic [31:0] buf_addr;
    logic [7:0]  buf_data;
    logic        sw_we = 1'b0, sw_word = 1'b0;
    logic [4:0]  sw_idx = '0;
    logic [31:0] sw_wdata = '0, sw_rdata;

    always #2 clk = ~clk;

    rx_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_match(rx_match),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .overrun(overrun), .sw_we(sw_we), .sw_idx(sw_idx), .sw_word(sw_word),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;

    int          nrec = 0, novr = 0;
    logic [31:0] rec_addr [1024];
    logic [7:0]  rec_data [1024];

    always @(negedge clk) begin
        if (rst_n && buf_we && nrec < 1024) begin
            rec_addr[nrec] = buf_addr;
            rec_data[nrec] = buf_data;
            nrec++;
        end
        if (rst_n && overrun) novr++;
    end

    // bench model of the ring
    int  rs = 4;
    int  bptr = 0;
    bit  own [NDESC];
    logic [31:0] exp_stat [NDESC];
    int  touched [64];
    int  nt = 0;
    logic [31:0] exp_addr [1024];
    logic [7:0]  exp_data [1024];
    int  nexp = 0;
    int  exp_drop = 0;

    function automatic logic [31:0] base_of(int i);
        return 32'h0000_1000 + 32'(i) * 32'h80;
    endfunction

    function automatic logic [31:0] word0_of(int i);
        return base_of(i) | ((i == rs - 1 && rs != NDESC) ? 32'h2 : 32'h0);
    endfunction

    function automatic logic [31:0] flag_bits(logic [5:0] m);
        return (32'(m[0]) << 26) | (32'(m[1]) << 25) | (32'(m[2]) << 24) |
               (32'(m[3]) << 23) | (32'(m[4]) << 22) | (32'(m[5]) << 31);
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic sw_write(int idx, bit word, logic [31:0] val);
        @(negedge clk);
        sw_we = 1'b1; sw_idx = 5'(idx); sw_word = word; sw_wdata = val;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_read(int idx, bit word, output logic [31:0] val);
        @(negedge clk);
        sw_idx = 5'(idx); sw_word = word;
        #1 val = sw_rdata;
    endtask

    task automatic init_ring(int size);
        rs = size; bptr = 0;
        for (int i = 0; i < NDESC; i++) begin
            own[i] = 1'b0;
            sw_write(i, 1'b0, word0_of(i));
            sw_write(i, 1'b1, 32'h0);
        end
    endtask

    task automatic build_expect(int len, logic [5:0] m, int seed);
        int p, off;
        p = bptr; nexp = 0; nt = 0; exp_drop = 0;
        for (int b = 0; b < len; b++) begin
            off = b % BB;
            if (off == 0 && own[p]) begin exp_drop = 1; break; end
            exp_addr[nexp] = base_of(p) + 32'(off);
            exp_data[nexp] = 8'((seed + b * 7) & 255);
            nexp++;
            if (b == len - 1 || off == BB - 1) begin
                exp_stat[p] = ((b == len - 1) ? 32'(len) : 32'h0) |
                              ((b < BB) ? 32'h4000 : 32'h0) |
                              ((b == len - 1) ? (32'h8000 | flag_bits(m)) : 32'h0);
                own[p] = 1'b1;
                touched[nt++] = p;
                p = (p + 1) % rs;
            end
        end
        bptr = p;
    endtask

    // coll: 0 none, 1 same descriptor status word, 2 other descriptor word 0
    task automatic drive_frame(int len, logic [5:0] m, int seed, int coll, int cidx, logic [31:0] cval);
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'((seed + b * 7) & 255);
            rx_sof = (b == 0); rx_eof = (b == len - 1); rx_match = m;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        if (coll != 0) begin
            sw_we = 1'b1; sw_idx = 5'(cidx); sw_word = (coll == 1); sw_wdata = cval;
            @(negedge clk);
            sw_we = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic verify(string tag);
        logic [31:0] v;
        int bad;
        bad = 0;
        for (int i = 0; i < nexp && i < nrec; i++)
            if (rec_addr[i] !== exp_addr[i] || rec_data[i] !== exp_data[i]) bad++;
        check(nrec == nexp && bad == 0, "R1 R2", {tag, " buffer writes"}, 32'(nrec), 32'(nexp));
        check(novr == exp_drop, "R8", {tag, " overrun count"}, 32'(novr), 32'(exp_drop));
        for (int k = 0; k < nt; k++) begin
            sw_read(touched[k], 1'b1, v);
            check(v === exp_stat[touched[k]], "R3 R4 R5", {tag, " status"}, v, exp_stat[touched[k]]);
            sw_read(touched[k], 1'b0, v);
            check(v === (word0_of(touched[k]) | 32'h1), "R6", {tag, " used bit"}, v, word0_of(touched[k]) | 32'h1);
        end
    endtask

    task automatic frame(int len, logic [5:0] m, int seed, string tag);
        nrec = 0; novr = 0;
        build_expect(len, m, seed);
        drive_frame(len, m, seed, 0, 0, 32'h0);
        verify(tag);
    endtask

    task automatic free_touched();
        for (int k = 0; k < nt; k++) begin
            sw_write(touched[k], 1'b0, word0_of(touched[k]));
            own[touched[k]] = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    int lens [15] = '{1, 2, 63, 127, 128, 129, 200, 255, 256, 257, 383, 384, 385, 511, 512};

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(buf_we == 1'b0 && overrun == 1'b0, "R12", "outputs in reset", {30'd0, buf_we, overrun}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NDESC; i++) begin
            sw_read(i, 1'b0, v);
            check(v === 32'h0, "R12", "word 0 after reset", v, 32'h0);
            sw_read(i, 1'b1, v);
            check(v === 32'h0, "R12", "word 1 after reset", v, 32'h0);
        end

        // sweep over boundary lengths on a ring of four (wrap bit on descriptor 3: R7)
        init_ring(4);
        for (int i = 0; i < 15; i++) begin
            frame(lens[i], 6'((i * 11) & 63), i * 13, "R7 sweep");
            free_touched();
        end

        // R8 full ring then overrun, pointer stays
        frame(512, 6'h3f, 5, "R8 fill");
        frame(50, 6'h01, 9, "R8 blocked");
        for (int i = 0; i < 4; i++) begin sw_write(i, 1'b0, word0_of(i)); own[i] = 1'b0; end
        frame(10, 6'h20, 3, "R8 resume");
        // R8 mid-frame: only the next three are free
        frame(400, 6'h02, 17, "R8 mid frame");
        free_touched();
        for (int i = 0; i < 4; i++) begin sw_write(i, 1'b0, word0_of(i)); own[i] = 1'b0; end

        // R11 stray bytes outside a frame
        nrec = 0; novr = 0;
        for (int b = 0; b < 5; b++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(b); rx_sof = 1'b0; rx_eof = (b == 4);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (3) @(negedge clk);
        check(nrec == 0 && novr == 0, "R11", "stray bytes ignored", 32'(nrec), 32'h0);
        frame(20, 6'h04, 21, "R11 next frame");
        free_touched();

        // R9 same-cycle collisions with the end writeback
        nrec = 0; novr = 0;
        build_expect(30, 6'h08, 41);
        drive_frame(30, 6'h08, 41, 1, touched[0], 32'hdead_beef);
        verify("R9 same word");
        free_touched();
        nrec = 0; novr = 0;
        build_expect(30, 6'h10, 43);
        drive_frame(30, 6'h10, 43, 2, (touched[0] + 2) % 4, word0_of((touched[0] + 2) % 4) | 32'h0000_0004);
        verify("R9 other word");
        sw_read((touched[0] + 2) % 4, 1'b0, v);
        check(v === (word0_of((touched[0] + 2) % 4) | 32'h4), "R9", "software write in writeback cycle", v,
              word0_of((touched[0] + 2) % 4) | 32'h4);
        sw_write((touched[0] + 2) % 4, 1'b0, word0_of((touched[0] + 2) % 4));
        free_touched();

        // R10 ring of one with a pending writeback
        do_reset();
        rs = 1; bptr = 0;
        for (int i = 0; i < NDESC; i++) own[i] = 1'b0;
        sw_write(0, 1'b0, word0_of(0));
        frame(200, 6'h3f, 61, "R10 ring of one");
        free_touched();
        frame(1, 6'h21, 63, "R10 self wrap");
        free_touched();

        // R7 natural end of ring at descriptor NDESC-1
        do_reset();
        init_ring(NDESC);
        for (int f = 0; f < 8; f++) begin
            frame(512, 6'(f), f * 3, "R7 full ring");
            free_touched();
        end
        frame(5, 6'h00, 77, "R7 back to zero");
        check(touched[0] == 0, "R7", "descriptor after last", 32'(touched[0]), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule